// File: doc/BRIEF.md
# Audio Port Routing Crossbar

This block is a configurable switch that sits between five external serial audio ports and three internal audio controllers. Each external port carries a bit clock, a frame sync and two serial data lines. Every line has an output value and an output enable for the pad. Software programs one control word per port and one per controller over a small 32-bit register bus. After that, the routing of every line is purely combinational.

A port can be fed by a controller, or it can be bridged to another port. In a bridge, one side supplies the clocks and the other side follows them. Each data line of a port is separately set to transmit or receive. A controller picks which port supplies its clock pair, and it picks the source for each of its two data inputs on its own. Several ports may take their data from the same controller, which broadcasts one stream to many ports. The block does not check that a configuration makes sense. Whatever is written is applied.

Top module: `audio_xbar`

## Requirements
- R1: After reset every register reads zero. With all registers at zero, every port is fed by controller 1: its bit clock and frame sync are driven from controller 1 with enables high, and both of its data lines are receive, with enable low and output 0. Every controller takes its clock, frame sync and both data inputs from port 1.
- R2: The bus works in single cycles. When `req_i` is high at a rising edge, `ready_o` is high for the following cycle, and it is low in any cycle that follows an edge without a request. For a read, `rdata_o` holds the data in that same cycle. It is zero after a write or after an idle cycle. A write changes the routing from the edge that accepts it.
- R3: Port k (k = 0..4) has its control word at byte address 4*k. Field `src` is bits [4:0]. Bit 31 is the role bit (1 = clock master when bridged). Bit 30 sets data line 1 to transmit, and bit 29 does the same for data line 2. On a read only these bits come back; every other bit reads 0.
- R4: Controller j (j = 0..2) has its word at byte address 0x40 + 4*j. The clock select is bits [3:0], the data-1 select is bits [27:24] and the data-2 select is bits [31:28]. Every other bit reads 0.
- R5: Every address other than the eight in R3 and R4 reads as zero, including misaligned addresses such as 0x41. A write to such an address changes no register.
- R6: When `src` is 0, 1 or 2, the port is fed by controller `src`+1. Its bit clock and frame sync are copied from that controller with enables high. A data line set to transmit copies the same-numbered data line of that controller with its enable high. A data line set to receive has enable 0 and output 0.
- R7: When `src` is 16..20, the port is bridged to port `src`-16. With the role bit at 0, the port copies that peer's incoming bit clock and frame sync with enables high. With the role bit at 1, its bit clock and frame sync enables are 0 and the outputs are 0.
- R8: In a bridge, a data line set to transmit copies the peer's incoming data line of the same number with its enable high. This holds whatever the role bit is.
- R9: A `src` value of 3..15 or 21..31 sets all four outputs of the port to 0 with all four enables low.
- R10: For a controller, a select of 0..4 picks port select+1. The clock select supplies both bit clock and frame sync, and each data select supplies its own data input. A select of 5..15 gives 0.
- R11: No consistency is enforced. Several ports may take the same controller at once, and a port may be bridged to itself. Both are applied as written.
- R12: Routing has no register stage. A change on an incoming port or controller line shows on the routed outputs in the same cycle, before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 8 (ADDR_W) | Byte address |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Request completed |
| rdata_o | output | 32 | Read data |
| port_bclk_i | input | 5 (N_PORT) | Incoming bit clock per port |
| port_fs_i | input | 5 | Incoming frame sync per port |
| port_d1_i | input | 5 | Incoming data line 1 per port |
| port_d2_i | input | 5 | Incoming data line 2 per port |
| port_bclk_o | output | 5 | Bit clock output per port |
| port_bclk_oe_o | output | 5 | Bit clock output enable |
| port_fs_o | output | 5 | Frame sync output |
| port_fs_oe_o | output | 5 | Frame sync output enable |
| port_d1_o | output | 5 | Data line 1 output |
| port_d1_oe_o | output | 5 | Data line 1 output enable |
| port_d2_o | output | 5 | Data line 2 output |
| port_d2_oe_o | output | 5 | Data line 2 output enable |
| ctrl_bclk_i | input | 3 (N_CTRL) | Bit clock sent by each controller |
| ctrl_fs_i | input | 3 | Frame sync sent by each controller |
| ctrl_d1_i | input | 3 | Data 1 sent by each controller |
| ctrl_d2_i | input | 3 | Data 2 sent by each controller |
| ctrl_bclk_o | output | 3 | Bit clock delivered to each controller |
| ctrl_fs_o | output | 3 | Frame sync delivered to each controller |
| ctrl_d1_o | output | 3 | Data 1 delivered to each controller |
| ctrl_d2_o | output | 3 | Data 2 delivered to each controller |

## Verification
The block has two kinds of result, and they are due at different times. `ready_o` and `rdata_o` are due one cycle after the edge that takes a request. A written word changes the routing from that same edge. Routed lines follow their inputs with no delay at all. The bench keeps a model that updates at each rising edge and compares every output a quarter period later, after both the design and the model have settled. The directed routing checks change pins on the falling edge and sample one time unit later, so any register stage on a routed path would be caught.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int REG_W  = 32;
  localparam int SRC_W  = 5;
  localparam int PSEL_W = 4;
  localparam logic [SRC_W-1:0] PEER_CODE0 = 5'd16;

  typedef struct packed {
    logic             master;
    logic             d1_tx;
    logic             d2_tx;
    logic [SRC_W-1:0] src;
  } port_cfg_t;

  typedef struct packed {
    logic [PSEL_W-1:0] d2_sel;
    logic [PSEL_W-1:0] d1_sel;
    logic [PSEL_W-1:0] clk_sel;
  } ctrl_cfg_t;

  typedef struct packed {
    logic bclk;
    logic fs;
    logic d1;
    logic d2;
  } lines_t;

  function automatic logic [REG_W-1:0] port_pack(port_cfg_t c);
    return {c.master, c.d1_tx, c.d2_tx, {(REG_W-3-SRC_W){1'b0}}, c.src};
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(ctrl_cfg_t c);
    return {c.d2_sel, c.d1_sel, {(REG_W-3*PSEL_W){1'b0}}, c.clk_sel};
  endfunction
endpackage

// File: rtl/xbar_regs.sv
module xbar_regs
  import xbar_pkg::*;
#(
  parameter int N_PORT    = 5,
  parameter int N_CTRL    = 3,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 0,
  parameter int CTRL_BASE = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic                         ready_o,
  output logic [REG_W-1:0]             rdata_o,
  output port_cfg_t [N_PORT-1:0]       port_cfg_o,
  output ctrl_cfg_t [N_CTRL-1:0]       ctrl_cfg_o
);
  localparam int STRIDE = 4;

  logic [N_PORT-1:0] port_hit;
  logic [N_CTRL-1:0] ctrl_hit;
  logic              wr_en;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_wdata;

  assign wr_en        = req_i & we_i;
  assign unused_wdata = ^wdata_i[23:5];

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    port_cfg_t q;
    assign port_hit[p] = (addr_i == ADDR_W'(PORT_BASE + STRIDE * p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_en && port_hit[p]) begin
        q.master <= wdata_i[31];
        q.d1_tx  <= wdata_i[30];
        q.d2_tx  <= wdata_i[29];
        q.src    <= wdata_i[SRC_W-1:0];
      end
    end
    assign port_cfg_o[p] = q;
  end

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    ctrl_cfg_t q;
    assign ctrl_hit[c] = (addr_i == ADDR_W'(CTRL_BASE + STRIDE * c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_en && ctrl_hit[c]) begin
        q.d2_sel  <= wdata_i[31:28];
        q.d1_sel  <= wdata_i[27:24];
        q.clk_sel <= wdata_i[PSEL_W-1:0];
      end
    end
    assign ctrl_cfg_o[c] = q;
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < N_PORT; p++)
      if (port_hit[p]) rd_mux = rd_mux | port_pack(port_cfg_o[p]);
    for (int c = 0; c < N_CTRL; c++)
      if (ctrl_hit[c]) rd_mux = rd_mux | ctrl_pack(ctrl_cfg_o[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= req_i;
      rdata_o <= (req_i && !we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/xbar_port_route.sv
module xbar_port_route
  import xbar_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTRL = 3
) (
  input  port_cfg_t               cfg_i,
  input  lines_t [N_CTRL-1:0]     ctrl_tx_i,
  input  lines_t [N_PORT-1:0]     pin_in_i,
  output lines_t                  pin_o,
  output lines_t                  pin_oe_o
);
  always_comb begin
    pin_o    = '0;
    pin_oe_o = '0;
    // controller feeds the port: controller always owns the clocks
    for (int c = 0; c < N_CTRL; c++) begin
      if (cfg_i.src == SRC_W'(c)) begin
        pin_o.bclk    = ctrl_tx_i[c].bclk;
        pin_o.fs      = ctrl_tx_i[c].fs;
        pin_oe_o.bclk = 1'b1;
        pin_oe_o.fs   = 1'b1;
        if (cfg_i.d1_tx) begin
          pin_o.d1    = ctrl_tx_i[c].d1;
          pin_oe_o.d1 = 1'b1;
        end
        if (cfg_i.d2_tx) begin
          pin_o.d2    = ctrl_tx_i[c].d2;
          pin_oe_o.d2 = 1'b1;
        end
      end
    end
    // port-to-port bridge: a master leaves its clock pads undriven
    for (int q = 0; q < N_PORT; q++) begin
      if (cfg_i.src == PEER_CODE0 + SRC_W'(q)) begin
        if (!cfg_i.master) begin
          pin_o.bclk    = pin_in_i[q].bclk;
          pin_o.fs      = pin_in_i[q].fs;
          pin_oe_o.bclk = 1'b1;
          pin_oe_o.fs   = 1'b1;
        end
        if (cfg_i.d1_tx) begin
          pin_o.d1    = pin_in_i[q].d1;
          pin_oe_o.d1 = 1'b1;
        end
        if (cfg_i.d2_tx) begin
          pin_o.d2    = pin_in_i[q].d2;
          pin_oe_o.d2 = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_ctrl_route.sv
module xbar_ctrl_route
  import xbar_pkg::*;
#(
  parameter int N_PORT = 5
) (
  input  ctrl_cfg_t               cfg_i,
  input  lines_t [N_PORT-1:0]     pin_in_i,
  output lines_t                  ctrl_rx_o
);
  always_comb begin
    ctrl_rx_o = '0;
    for (int q = 0; q < N_PORT; q++) begin
      if (cfg_i.clk_sel == PSEL_W'(q)) begin
        ctrl_rx_o.bclk = pin_in_i[q].bclk;
        ctrl_rx_o.fs   = pin_in_i[q].fs;
      end
      if (cfg_i.d1_sel == PSEL_W'(q)) ctrl_rx_o.d1 = pin_in_i[q].d1;
      if (cfg_i.d2_sel == PSEL_W'(q)) ctrl_rx_o.d2 = pin_in_i[q].d2;
    end
  end
endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
  import xbar_pkg::*;
#(
  parameter int N_PORT    = 5,
  parameter int N_CTRL    = 3,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 0,
  parameter int CTRL_BASE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              ready_o,
  output logic [31:0]       rdata_o,
  input  logic [N_PORT-1:0] port_bclk_i,
  input  logic [N_PORT-1:0] port_fs_i,
  input  logic [N_PORT-1:0] port_d1_i,
  input  logic [N_PORT-1:0] port_d2_i,
  output logic [N_PORT-1:0] port_bclk_o,
  output logic [N_PORT-1:0] port_bclk_oe_o,
  output logic [N_PORT-1:0] port_fs_o,
  output logic [N_PORT-1:0] port_fs_oe_o,
  output logic [N_PORT-1:0] port_d1_o,
  output logic [N_PORT-1:0] port_d1_oe_o,
  output logic [N_PORT-1:0] port_d2_o,
  output logic [N_PORT-1:0] port_d2_oe_o,
  input  logic [N_CTRL-1:0] ctrl_bclk_i,
  input  logic [N_CTRL-1:0] ctrl_fs_i,
  input  logic [N_CTRL-1:0] ctrl_d1_i,
  input  logic [N_CTRL-1:0] ctrl_d2_i,
  output logic [N_CTRL-1:0] ctrl_bclk_o,
  output logic [N_CTRL-1:0] ctrl_fs_o,
  output logic [N_CTRL-1:0] ctrl_d1_o,
  output logic [N_CTRL-1:0] ctrl_d2_o
);
  port_cfg_t [N_PORT-1:0] port_cfg;
  ctrl_cfg_t [N_CTRL-1:0] ctrl_cfg;
  lines_t    [N_PORT-1:0] pin_in, pin_out, pin_oe;
  lines_t    [N_CTRL-1:0] ctrl_tx, ctrl_rx;

  xbar_regs #(
    .N_PORT(N_PORT), .N_CTRL(N_CTRL), .ADDR_W(ADDR_W),
    .PORT_BASE(PORT_BASE), .CTRL_BASE(CTRL_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ready_o, .rdata_o,
    .port_cfg_o(port_cfg),
    .ctrl_cfg_o(ctrl_cfg)
  );

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign pin_in[p] = {port_bclk_i[p], port_fs_i[p], port_d1_i[p], port_d2_i[p]};

    xbar_port_route #(.N_PORT(N_PORT), .N_CTRL(N_CTRL)) u_route (
      .cfg_i    (port_cfg[p]),
      .ctrl_tx_i(ctrl_tx),
      .pin_in_i (pin_in),
      .pin_o    (pin_out[p]),
      .pin_oe_o (pin_oe[p])
    );

    assign port_bclk_o[p]    = pin_out[p].bclk;
    assign port_fs_o[p]      = pin_out[p].fs;
    assign port_d1_o[p]      = pin_out[p].d1;
    assign port_d2_o[p]      = pin_out[p].d2;
    assign port_bclk_oe_o[p] = pin_oe[p].bclk;
    assign port_fs_oe_o[p]   = pin_oe[p].fs;
    assign port_d1_oe_o[p]   = pin_oe[p].d1;
    assign port_d2_oe_o[p]   = pin_oe[p].d2;
  end

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    assign ctrl_tx[c] = {ctrl_bclk_i[c], ctrl_fs_i[c], ctrl_d1_i[c], ctrl_d2_i[c]};

    xbar_ctrl_route #(.N_PORT(N_PORT)) u_route (
      .cfg_i    (ctrl_cfg[c]),
      .pin_in_i (pin_in),
      .ctrl_rx_o(ctrl_rx[c])
    );

    assign ctrl_bclk_o[c] = ctrl_rx[c].bclk;
    assign ctrl_fs_o[c]   = ctrl_rx[c].fs;
    assign ctrl_d1_o[c]   = ctrl_rx[c].d1;
    assign ctrl_d2_o[c]   = ctrl_rx[c].d2;
  end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int N_PORT    = 5,
  parameter int N_CTRL    = 3,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 0,
  parameter int CTRL_BASE = 64
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   ready_o,
  input logic [31:0]            rdata_o,
  input port_cfg_t [N_PORT-1:0] port_cfg_i,
  input logic [N_PORT-1:0]      port_bclk_o,
  input logic [N_PORT-1:0]      port_bclk_oe_o,
  input logic [N_PORT-1:0]      port_fs_o,
  input logic [N_PORT-1:0]      port_fs_oe_o,
  input logic [N_PORT-1:0]      port_d1_o,
  input logic [N_PORT-1:0]      port_d1_oe_o,
  input logic [N_PORT-1:0]      port_d2_o,
  input logic [N_PORT-1:0]      port_d2_oe_o
);
  function automatic logic is_dec(logic [ADDR_W-1:0] a);
    logic hit = 1'b0;
    for (int i = 0; i < N_PORT; i++) if (a == ADDR_W'(PORT_BASE + 4 * i)) hit = 1'b1;
    for (int i = 0; i < N_CTRL; i++) if (a == ADDR_W'(CTRL_BASE + 4 * i)) hit = 1'b1;
    return hit;
  endfunction

  // R2
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) req_i |=> ready_o);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !req_i |=> !ready_o && rdata_o == '0);
  // R2
  wr_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i && we_i) |=> rdata_o == '0);
  // R5
  undec_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !is_dec(addr_i)) |=> rdata_o == '0);

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    logic unused_src, peer_src;
    assign peer_src   = (port_cfg_i[p].src >= PEER_CODE0) &&
                        (port_cfg_i[p].src < PEER_CODE0 + SRC_W'(N_PORT));
    assign unused_src = (port_cfg_i[p].src >= SRC_W'(N_CTRL)) && !peer_src;

    // R9
    unused_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unused_src |-> ({port_bclk_oe_o[p], port_fs_oe_o[p], port_d1_oe_o[p], port_d2_oe_o[p],
                       port_bclk_o[p], port_fs_o[p], port_d1_o[p], port_d2_o[p]} == '0));
    // R6
    rx1_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_cfg_i[p].d1_tx |-> !port_d1_oe_o[p] && !port_d1_o[p]);
    // R6
    rx2_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_cfg_i[p].d2_tx |-> !port_d2_oe_o[p] && !port_d2_o[p]);
    // R7
    master_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (peer_src && port_cfg_i[p].master) |-> !port_bclk_oe_o[p] && !port_fs_oe_o[p]);
  end
endmodule

bind audio_xbar xbar_chk #(
  .N_PORT(N_PORT), .N_CTRL(N_CTRL), .ADDR_W(ADDR_W),
  .PORT_BASE(PORT_BASE), .CTRL_BASE(CTRL_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .ready_o(ready_o), .rdata_o(rdata_o), .port_cfg_i(port_cfg),
  .port_bclk_o(port_bclk_o), .port_bclk_oe_o(port_bclk_oe_o),
  .port_fs_o(port_fs_o), .port_fs_oe_o(port_fs_oe_o),
  .port_d1_o(port_d1_o), .port_d1_oe_o(port_d1_oe_o),
  .port_d2_o(port_d2_o), .port_d2_oe_o(port_d2_oe_o)
);

// File: tb/tb_audio_xbar.sv
module tb_audio_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int NC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ready;
  logic [31:0] rdata;
  logic [NP-1:0] port_bclk_i = '0, port_fs_i = '0, port_d1_i = '0, port_d2_i = '0;
  logic [NP-1:0] port_bclk_o, port_bclk_oe_o, port_fs_o, port_fs_oe_o;
  logic [NP-1:0] port_d1_o, port_d1_oe_o, port_d2_o, port_d2_oe_o;
  logic [NC-1:0] ctrl_bclk_i = '0, ctrl_fs_i = '0, ctrl_d1_i = '0, ctrl_d2_i = '0;
  logic [NC-1:0] ctrl_bclk_o, ctrl_fs_o, ctrl_d1_o, ctrl_d2_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_xbar dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata),
    .port_bclk_i, .port_fs_i, .port_d1_i, .port_d2_i,
    .port_bclk_o, .port_bclk_oe_o, .port_fs_o, .port_fs_oe_o,
    .port_d1_o, .port_d1_oe_o, .port_d2_o, .port_d2_oe_o,
    .ctrl_bclk_i, .ctrl_fs_i, .ctrl_d1_i, .ctrl_d2_i,
    .ctrl_bclk_o, .ctrl_fs_o, .ctrl_d1_o, .ctrl_d2_o
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_port [NP];
  logic [31:0] m_ctrl [NC];
  logic        m_ready;
  logic [31:0] m_rdata;

  function automatic int port_idx(logic [7:0] a);
    for (int i = 0; i < NP; i++) if (a == 8'(4 * i)) return i;
    return -1;
  endfunction

  function automatic int ctrl_idx(logic [7:0] a);
    for (int i = 0; i < NC; i++) if (a == 8'(64 + 4 * i)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (port_idx(a) >= 0) return m_port[port_idx(a)];
    if (ctrl_idx(a) >= 0) return m_ctrl[ctrl_idx(a)];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_port[i] <= '0;
      for (int i = 0; i < NC; i++) m_ctrl[i] <= '0;
      m_ready <= 1'b0;
      m_rdata <= '0;
    end else begin
      m_ready <= req;
      m_rdata <= (req && !we) ? m_read(addr) : 32'h0;
      if (req && we) begin
        if (port_idx(addr) >= 0) m_port[port_idx(addr)] <= wdata & 32'hE000_001F;
        if (ctrl_idx(addr) >= 0) m_ctrl[ctrl_idx(addr)] <= wdata & 32'hFF00_000F;
      end
    end
  end

  function automatic string ptag(logic [31:0] w);
    int s = int'(w[4:0]);
    if (s < NC) return "R6";
    if (s >= 16 && s < 16 + NP) return "R7/R8";
    return "R9";
  endfunction

  task automatic compare_all();
    logic [NP-1:0] eb, ebe, ef, efe, e1, e1e, e2, e2e;
    logic [NC-1:0] cb, cf, c1, c2;
    eb = '0; ebe = '0; ef = '0; efe = '0; e1 = '0; e1e = '0; e2 = '0; e2e = '0;
    cb = '0; cf = '0; c1 = '0; c2 = '0;
    for (int p = 0; p < NP; p++) begin
      int s = int'(m_port[p][4:0]);
      if (s < NC) begin
        eb[p] = ctrl_bclk_i[s]; ebe[p] = 1'b1;
        ef[p] = ctrl_fs_i[s];   efe[p] = 1'b1;
        if (m_port[p][30]) begin e1[p] = ctrl_d1_i[s]; e1e[p] = 1'b1; end
        if (m_port[p][29]) begin e2[p] = ctrl_d2_i[s]; e2e[p] = 1'b1; end
      end else if (s >= 16 && s < 16 + NP) begin
        int q = s - 16;
        if (!m_port[p][31]) begin
          eb[p] = port_bclk_i[q]; ebe[p] = 1'b1;
          ef[p] = port_fs_i[q];   efe[p] = 1'b1;
        end
        if (m_port[p][30]) begin e1[p] = port_d1_i[q]; e1e[p] = 1'b1; end
        if (m_port[p][29]) begin e2[p] = port_d2_i[q]; e2e[p] = 1'b1; end
      end
    end
    for (int c = 0; c < NC; c++) begin
      int k = int'(m_ctrl[c][3:0]);
      int k1 = int'(m_ctrl[c][27:24]);
      int k2 = int'(m_ctrl[c][31:28]);
      if (k < NP) begin cb[c] = port_bclk_i[k]; cf[c] = port_fs_i[k]; end
      if (k1 < NP) c1[c] = port_d1_i[k1];
      if (k2 < NP) c2[c] = port_d2_i[k2];
    end
    for (int p = 0; p < NP; p++) begin
      string t = ptag(m_port[p]);
      check(t, "bclk",    32'(port_bclk_o[p]),    32'(eb[p]));
      check(t, "bclk_oe", 32'(port_bclk_oe_o[p]), 32'(ebe[p]));
      check(t, "fs",      32'(port_fs_o[p]),      32'(ef[p]));
      check(t, "fs_oe",   32'(port_fs_oe_o[p]),   32'(efe[p]));
      check(t, "d1",      32'(port_d1_o[p]),      32'(e1[p]));
      check(t, "d1_oe",   32'(port_d1_oe_o[p]),   32'(e1e[p]));
      check(t, "d2",      32'(port_d2_o[p]),      32'(e2[p]));
      check(t, "d2_oe",   32'(port_d2_oe_o[p]),   32'(e2e[p]));
    end
    check("R10", "ctrl_bclk", 32'(ctrl_bclk_o), 32'(cb));
    check("R10", "ctrl_fs",   32'(ctrl_fs_o),   32'(cf));
    check("R10", "ctrl_d1",   32'(ctrl_d1_o),   32'(c1));
    check("R10", "ctrl_d2",   32'(ctrl_d2_o),   32'(c2));
    check("R2", "ready", 32'(ready), 32'(m_ready));
    check("R2", "rdata", rdata, m_rdata);
  endtask

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) compare_all();
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check("R2", "ready on read", 32'(ready), 32'd1);
    d = rdata;
  endtask

  task automatic read_expect(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, $sformatf("read %h", a), d, exp);
  endtask

  function automatic logic [7:0] pick_addr(int r);
    case (r % 12)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
      4: return 8'h10;  5: return 8'h40;  6: return 8'h44;  7: return 8'h48;
      8: return 8'h14;  9: return 8'h4C;  10: return 8'h41; default: return 8'h80;
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    port_bclk_i = 5'b00001; ctrl_bclk_i = 3'b001; ctrl_fs_i = 3'b001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset routing
    check("R1", "bclk_oe all ports", 32'(port_bclk_oe_o), 32'h1F);
    check("R1", "bclk from ctrl 1",  32'(port_bclk_o),    32'h1F);
    check("R1", "d1_oe off",         32'(port_d1_oe_o),   32'h0);
    check("R1", "ctrl bclk from port 1", 32'(ctrl_bclk_o), 32'h7);
    for (int i = 0; i < NP; i++) read_expect("R1", 8'(4 * i), 32'h0);
    for (int i = 0; i < NC; i++) read_expect("R1", 8'(64 + 4 * i), 32'h0);

    // R3 port word layout
    bus_write(8'h04, 32'hFFFF_FFE1);
    read_expect("R3", 8'h04, 32'hE000_0001);
    bus_write(8'h04, 32'h1FFF_FFF2);
    read_expect("R3", 8'h04, 32'h0000_0012);
    // R4 controller word layout
    bus_write(8'h44, 32'hFFFF_FFFF);
    read_expect("R4", 8'h44, 32'hFF00_000F);
    bus_write(8'h44, 32'h00FF_FFF2);
    read_expect("R4", 8'h44, 32'h0000_0002);

    // R5 undecoded addresses
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'h4C, 32'hFFFF_FFFF);
    bus_write(8'h41, 32'hFFFF_FFFF);
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    read_expect("R5", 8'h00, 32'h0);
    read_expect("R5", 8'h04, 32'h0000_0012);
    read_expect("R5", 8'h10, 32'h0);
    read_expect("R5", 8'h40, 32'h0);
    read_expect("R5", 8'h44, 32'h0000_0002);
    read_expect("R5", 8'h48, 32'h0);
    read_expect("R5", 8'h14, 32'h0);
    read_expect("R5", 8'h41, 32'h0);
    read_expect("R5", 8'h4C, 32'h0);

    // R6 port 1 from controller 2, line 1 transmit
    bus_write(8'h00, 32'h4000_0001);
    ctrl_d1_i = 3'b010; ctrl_bclk_i = 3'b010; ctrl_d2_i = 3'b010;
    #1;
    check("R6", "d1 from ctrl 2", 32'(port_d1_o[0]),    32'd1);
    check("R6", "d1_oe",          32'(port_d1_oe_o[0]), 32'd1);
    check("R6", "d2 receive oe",  32'(port_d2_oe_o[0]), 32'd0);
    check("R6", "d2 receive out", 32'(port_d2_o[0]),    32'd0);
    check("R6", "bclk from ctrl 2", 32'(port_bclk_o[0]), 32'd1);

    // R7 / R8 port 3 bridged to port 4
    bus_write(8'h08, 32'h4000_0013);
    port_bclk_i = 5'b01000; port_d1_i = 5'b01000;
    #1;
    check("R7", "slave bclk",    32'(port_bclk_o[2]),    32'd1);
    check("R7", "slave bclk_oe", 32'(port_bclk_oe_o[2]), 32'd1);
    check("R8", "bridged d1",    32'(port_d1_o[2]),      32'd1);
    bus_write(8'h08, 32'hC000_0013);
    #1;
    check("R7", "master bclk_oe", 32'(port_bclk_oe_o[2]), 32'd0);
    check("R7", "master fs_oe",   32'(port_fs_oe_o[2]),   32'd0);
    check("R8", "master d1 still tx", 32'(port_d1_oe_o[2]), 32'd1);

    // R9 unused codes
    bus_write(8'h10, 32'h6000_000A);
    #1;
    check("R9", "code 10 enables", 32'({port_bclk_oe_o[4], port_fs_oe_o[4], port_d1_oe_o[4], port_d2_oe_o[4]}), 32'h0);
    bus_write(8'h10, 32'h6000_0015);
    #1;
    check("R9", "code 21 enables", 32'({port_bclk_oe_o[4], port_fs_oe_o[4], port_d1_oe_o[4], port_d2_oe_o[4]}), 32'h0);

    // R10 controller 3 selects
    bus_write(8'h48, 32'h4200_0003);
    port_bclk_i = 5'b01000; port_fs_i = 5'b01000; port_d1_i = 5'b00100; port_d2_i = 5'b10000;
    #1;
    check("R10", "clk sel 3",  32'(ctrl_bclk_o[2]), 32'd1);
    check("R10", "fs sel 3",   32'(ctrl_fs_o[2]),   32'd1);
    check("R10", "d1 sel 2",   32'(ctrl_d1_o[2]),   32'd1);
    check("R10", "d2 sel 4",   32'(ctrl_d2_o[2]),   32'd1);
    bus_write(8'h48, 32'h4200_0007);
    #1;
    check("R10", "clk sel 7 gives 0", 32'(ctrl_bclk_o[2]), 32'd0);

    // R11 broadcast and self bridge
    bus_write(8'h04, 32'h6000_0002);
    bus_write(8'h08, 32'h6000_0002);
    bus_write(8'h0C, 32'h6000_0002);
    ctrl_d1_i = 3'b100;
    #1;
    check("R11", "broadcast d1", 32'(port_d1_o[3:1]), 32'h7);
    bus_write(8'h10, 32'h4000_0014);
    port_d1_i = 5'b10000;
    #1;
    check("R11", "self bridge d1", 32'(port_d1_o[4]), 32'd1);

    // R12 same-cycle propagation
    bus_write(8'h08, 32'h4000_0013);
    port_bclk_i[3] = 1'b0;
    #1;
    check("R12", "bclk follows low", 32'(port_bclk_o[2]), 32'd0);
    port_bclk_i[3] = 1'b1;
    #1;
    check("R12", "bclk follows high", 32'(port_bclk_o[2]), 32'd1);

    // mixed traffic, compared every cycle
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      port_bclk_i = NP'($urandom); port_fs_i = NP'($urandom);
      port_d1_i = NP'($urandom);   port_d2_i = NP'($urandom);
      ctrl_bclk_i = NC'($urandom); ctrl_fs_i = NC'($urandom);
      ctrl_d1_i = NC'($urandom);   ctrl_d2_i = NC'($urandom);
      req = ($urandom % 4) == 0;
      we = $urandom % 2;
      addr = pick_addr(int'($urandom % 12));
      wdata = $urandom;
      if ($urandom % 4 != 0) begin
        int r = int'($urandom % 8);
        wdata[4:0] = (r < 3) ? 5'(r) : 5'(16 + (r - 3));
      end
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule